// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block runs an 8-bit bidirectional peripheral port for a processor. Each pin has its own direction bit; pins set as outputs carry the value of an output register, and pins set as inputs are read back either live or from a capture taken on an active edge of a strobe input. The capture is held until the processor reads it. After that read, the input path is transparent again until the next active strobe edge.

A second control line works in one of eight modes. In four of them it is an edge-sensitive interrupt input. In the others it is an output: a handshake level, a one-cycle pulse, a constant low or a constant high. In the two output modes that handshake, a processor read or write of the data register at offset 1 drives the line low. This gives a "data taken" signal for reads and a "data ready" signal for writes. Offset 15 reaches the same data but has no handshake effect and clears no flag. Two interrupt flags report strobe edges and control-line edges. The flags are brought out as pins and can also be read and cleared through a flag register.

Top module: `hs_port_ctrl`

## Requirements
- R1: After reset every register is zero. All pins are inputs (`pin_oe`=0, `pin_out`=0), the control line is released (`ctl2_oe`=0), both flags are clear, and the control register at offset 12 reads 0.
- R2: The direction register sits at offset 3 and reads back. `pin_oe[i]` is 1 exactly when direction bit i is 1 (1 = output, 0 = input).
- R3: A write to offset 1 or offset 15 loads the output register. `pin_out[i]` carries output-register bit i only while pin i is an output and is 0 otherwise. Bits written while a pin is an input are kept and appear on the pin once it becomes an output.
- R4: When latching is disabled (control bit 4 = 0), a read of offset 1 or 15 returns the live `pin_in` levels.
- R5: When latching is enabled, an active strobe edge that arrives while no capture is held stores `pin_in`. Later reads of the data return the stored value until one read has returned it; after that, reads are live again. Further active edges do not overwrite a held capture.
- R6: Control bit 0 selects the active strobe edge (0 = falling, 1 = rising). `strb_in` passes through a two-flop synchronizer. An active edge sets `irq_strb` on the third rising clock edge after the pin changes. The opposite edge sets nothing.
- R7: Control bits 3:1 give the control-line mode: 000/001 falling-edge input, 010/011 rising-edge input (001 and 011 are the independent variants), 100 handshake, 101 pulse, 110 constant low, 111 constant high. In the input modes, the selected synchronized `ctl2_in` edge sets `irq_ctl2`, and `ctl2_oe`=0.
- R8: A read or write of offset 1 clears `irq_strb`. It also clears `irq_ctl2`, except in the independent modes, where `irq_ctl2` is left unchanged. Accesses to offset 15 clear neither flag. A flag set in the same cycle as a clearing access stays set.
- R9: In handshake mode, an access to offset 1 drives `ctl2_out` low from the next clock. The line stays low until an active strobe edge is detected, and then returns high.
- R10: In pulse mode, an access to offset 1 drives `ctl2_out` low for exactly one clock cycle. Accesses to offset 15 leave it high.
- R11: In the constant modes, `ctl2_out` is the fixed level. `ctl2_oe` is 1 in every output mode (control bit 3 set).
- R12: The flag register at offset 13 reads {6'b0, `irq_ctl2`, `irq_strb`}. Writing 1 to bit 0 or bit 1 clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_sel | input | 4 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| strb_in | input | 1 | Edge-sensitive strobe input |
| ctl2_in | input | 1 | Control line input level |
| ctl2_out | output | 1 | Control line output level |
| ctl2_oe | output | 1 | Control line output enable |
| irq_strb | output | 1 | Strobe edge flag |
| irq_ctl2 | output | 1 | Control line edge flag |

## Verification
The hardest state to reach is a held capture that has to survive a second active strobe edge and then give way to live data after exactly one read. To reach it, the stimulus captures one pattern, moves the pins to a new value, and sends a full opposite-then-active strobe pair. It then reads twice through the side-effect-free offset and expects the old pattern first and the live pins second. The handshake release is also timing-sensitive. The stimulus lowers the line, confirms it is still low two cycles after the strobe moves, and checks that it has risen on the third cycle, which matches the synchronizer depth.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] OFS_DATA_HS  = 4'd1;
  localparam logic [SEL_W-1:0] OFS_DIR      = 4'd3;
  localparam logic [SEL_W-1:0] OFS_CTL      = 4'd12;
  localparam logic [SEL_W-1:0] OFS_FLAG     = 4'd13;
  localparam logic [SEL_W-1:0] OFS_DATA_RAW = 4'd15;

  typedef enum logic [2:0] {
    C2_IN_FALL     = 3'b000,
    C2_IN_FALL_IND = 3'b001,
    C2_IN_RISE     = 3'b010,
    C2_IN_RISE_IND = 3'b011,
    C2_HS          = 3'b100,
    C2_PULSE       = 3'b101,
    C2_LOW         = 3'b110,
    C2_HIGH        = 3'b111
  } c2_mode_e;

  typedef struct packed {
    logic     latch_en;
    c2_mode_e c2_mode;
    logic     strb_rise;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
    end
  end

  always_comb begin
    if (rise_sel) edge_o = sync_q[LAST] & ~prev_q;
    else          edge_o = ~sync_q[LAST] & prev_q;
  end
endmodule

// File: rtl/hs_in_latch.sv
module hs_in_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         latch_en,
  input  logic         cap_ev,
  input  logic         rd_ev,
  output logic [W-1:0] rd_val
);
  logic         hold_q, hold_d;
  logic [W-1:0] data_q, data_d;
  logic         cap_ok;

  always_comb begin
    hold_d = hold_q;
    data_d = data_q;
    cap_ok = cap_ev & latch_en & (~hold_q | rd_ev);
    if (cap_ok) begin
      hold_d = 1'b1;
      data_d = pins;
    end else if (rd_ev) begin
      hold_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      data_q <= '0;
    end else begin
      hold_q <= hold_d;
      if (cap_ok) data_q <= data_d;
    end
  end

  assign rd_val = (latch_en && hold_q) ? data_q : pins;
endmodule

// File: rtl/hs_ctl2_unit.sv
module hs_ctl2_unit
  import hs_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  c2_mode_e mode,
  input  logic     acc_hs,
  input  logic     strb_ev,
  output logic     line_out,
  output logic     line_oe
);
  logic hs_low_q, hs_low_d;
  logic pls_q, pls_d;

  always_comb begin
    hs_low_d = hs_low_q;
    if (mode != C2_HS)  hs_low_d = 1'b0;
    else if (acc_hs)    hs_low_d = 1'b1;
    else if (strb_ev)   hs_low_d = 1'b0;
    pls_d = (mode == C2_PULSE) && acc_hs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_low_q <= 1'b0;
      pls_q    <= 1'b0;
    end else begin
      hs_low_q <= hs_low_d;
      pls_q    <= pls_d;
    end
  end

  always_comb begin
    unique case (mode)
      C2_HS:    line_out = ~hs_low_q;
      C2_PULSE: line_out = ~pls_q;
      C2_LOW:   line_out = 1'b0;
      C2_HIGH:  line_out = 1'b1;
      default:  line_out = 1'b1;
    endcase
    line_oe = mode[2];
  end
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [SEL_W-1:0] bus_sel,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe,
  input  logic             strb_in,
  input  logic             ctl2_in,
  output logic             ctl2_out,
  output logic             ctl2_oe,
  output logic             irq_strb,
  output logic             irq_ctl2
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] out_q, out_d;
  ctl_t         ctl_q, ctl_d;
  logic         f1_q, f1_d, f2_q, f2_d;

  logic acc_hs, acc_raw, rd_data, wr_data, wr_dir, wr_ctl, wr_flag;
  logic strb_ev, c2_raw_ev, c2_ev, c2_indep;
  logic [W-1:0] in_val;

  always_comb begin
    acc_hs  = (bus_rd | bus_wr) & (bus_sel == OFS_DATA_HS);
    acc_raw = (bus_rd | bus_wr) & (bus_sel == OFS_DATA_RAW);
    rd_data = bus_rd & ((bus_sel == OFS_DATA_HS) | (bus_sel == OFS_DATA_RAW));
    wr_data = bus_wr & ((bus_sel == OFS_DATA_HS) | (bus_sel == OFS_DATA_RAW));
    wr_dir  = bus_wr & (bus_sel == OFS_DIR);
    wr_ctl  = bus_wr & (bus_sel == OFS_CTL);
    wr_flag = bus_wr & (bus_sel == OFS_FLAG);
    c2_indep = ~ctl_q.c2_mode[2] & ctl_q.c2_mode[0];
    c2_ev   = c2_raw_ev & ~ctl_q.c2_mode[2];
  end

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_strb_sync (
    .clk(clk), .rst_n(rst_i_n), .din(strb_in),
    .rise_sel(ctl_q.strb_rise), .edge_o(strb_ev)
  );

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_c2_sync (
    .clk(clk), .rst_n(rst_i_n), .din(ctl2_in),
    .rise_sel(ctl_q.c2_mode[1]), .edge_o(c2_raw_ev)
  );

  hs_in_latch #(.W(W)) u_in_latch (
    .clk(clk), .rst_n(rst_i_n), .pins(pin_in),
    .latch_en(ctl_q.latch_en), .cap_ev(strb_ev),
    .rd_ev(rd_data), .rd_val(in_val)
  );

  hs_ctl2_unit u_ctl2 (
    .clk(clk), .rst_n(rst_i_n), .mode(ctl_q.c2_mode),
    .acc_hs(acc_hs), .strb_ev(strb_ev),
    .line_out(ctl2_out), .line_oe(ctl2_oe)
  );

  always_comb begin
    dir_d = wr_dir  ? bus_wdata : dir_q;
    out_d = wr_data ? bus_wdata : out_q;
    ctl_d = wr_ctl  ? ctl_t'(bus_wdata[CTL_W-1:0]) : ctl_q;

    f1_d = f1_q;
    if (strb_ev)                     f1_d = 1'b1;
    else if (acc_hs)                 f1_d = 1'b0;
    else if (wr_flag && bus_wdata[0]) f1_d = 1'b0;

    f2_d = f2_q;
    if (c2_ev)                       f2_d = 1'b1;
    else if (acc_hs && !c2_indep)    f2_d = 1'b0;
    else if (wr_flag && bus_wdata[1]) f2_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      dir_q <= '0;
      out_q <= '0;
      ctl_q <= '0;
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
    end else begin
      if (wr_dir)  dir_q <= dir_d;
      if (wr_data) out_q <= out_d;
      if (wr_ctl)  ctl_q <= ctl_d;
      f1_q <= f1_d;
      f2_q <= f2_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_sel)
      OFS_DATA_HS, OFS_DATA_RAW: bus_rdata = in_val;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_CTL:  bus_rdata = W'(ctl_q);
      OFS_FLAG: bus_rdata = W'({f2_q, f1_q});
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out  = out_q & dir_q;
  assign pin_oe   = dir_q;
  assign irq_strb = f1_q;
  assign irq_ctl2 = f2_q;

  logic unused_acc_raw;
  assign unused_acc_raw = acc_raw;
endmodule

// File: rtl/hs_port_ctrl_chk.sv
module hs_port_ctrl_chk
  import hs_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [SEL_W-1:0] bus_sel,
  input logic [W-1:0]     bus_wdata,
  input logic [W-1:0]     pin_oe,
  input logic             ctl2_out,
  input logic             ctl2_oe,
  input logic             irq_strb,
  input logic             irq_ctl2,
  input ctl_t             ctl_q,
  input logic             strb_ev,
  input logic             c2_ev
);
  logic acc1, ctlwr;
  assign acc1  = (bus_rd | bus_wr) & (bus_sel == OFS_DATA_HS);
  assign ctlwr = bus_wr & (bus_sel == OFS_CTL);

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == OFS_DIR) |=> pin_oe == $past(bus_wdata));

  // R6
  strb_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_ev |=> irq_strb);

  // R8
  strb_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1 && !strb_ev) |=> !irq_strb);

  // R8
  indep_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc1 && !c2_ev && (ctl_q.c2_mode == C2_IN_FALL_IND || ctl_q.c2_mode == C2_IN_RISE_IND))
    |=> irq_ctl2 == $past(irq_ctl2));

  // R9
  hs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.c2_mode == C2_HS && acc1 && !ctlwr) |=> !ctl2_out);

  // R10
  pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.c2_mode == C2_PULSE && acc1 && !ctlwr) |=> !ctl2_out);

  // R10
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.c2_mode == C2_PULSE && !acc1 && !ctlwr) |=> ctl2_out);

  // R11
  const_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.c2_mode == C2_LOW) |-> (ctl2_oe && !ctl2_out));
endmodule

bind hs_port_ctrl hs_port_ctrl_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_sel(bus_sel), .bus_wdata(bus_wdata), .pin_oe(pin_oe),
  .ctl2_out(ctl2_out), .ctl2_oe(ctl2_oe), .irq_strb(irq_strb),
  .irq_ctl2(irq_ctl2), .ctl_q(ctl_q), .strb_ev(strb_ev), .c2_ev(c2_ev)
);

// File: tb/hs_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module hs_port_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       strb_in = 1'b0, ctl2_in = 1'b0;
  logic       ctl2_out, ctl2_oe, irq_strb, irq_ctl2;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  hs_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .strb_in(strb_in), .ctl2_in(ctl2_in), .ctl2_out(ctl2_out),
    .ctl2_oe(ctl2_oe), .irq_strb(irq_strb), .irq_ctl2(irq_ctl2)
  );

  // vector: kind(2) sel(4) wdata(8) pins(8) exp(8)
  // kind 0 = write, 1 = read and compare, 2 = compare pin_oe, 3 = compare pin_out
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 4'd3,  8'h0F, 8'h00, 8'h00},
    {2'd0, 4'd15, 8'hA5, 8'h00, 8'h00},
    {2'd2, 4'd0,  8'h00, 8'h00, 8'h0F},  // R2
    {2'd3, 4'd0,  8'h00, 8'h00, 8'h05},  // R3 masked by direction
    {2'd0, 4'd3,  8'hFF, 8'h00, 8'h00},
    {2'd3, 4'd0,  8'h00, 8'h00, 8'hA5},  // R3 stored bits appear
    {2'd1, 4'd3,  8'h00, 8'h00, 8'hFF},  // R2 readback
    {2'd0, 4'd3,  8'h00, 8'h00, 8'h00},
    {2'd1, 4'd15, 8'h00, 8'h3C, 8'h3C},  // R4 live
    {2'd1, 4'd15, 8'h00, 8'hC3, 8'hC3},  // R4 live
    {2'd0, 4'd12, 8'h10, 8'hC3, 8'h00},
    {2'd1, 4'd12, 8'h00, 8'hC3, 8'h10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic strb_to(input logic v);
    @(negedge clk);
    strb_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic c2_to(input logic v);
    @(negedge clk);
    ctl2_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 out", pin_out, 8'h00);
    chk("R1 ctl2_oe/flags", {5'b0, ctl2_oe, irq_ctl2, irq_strb}, 8'h00);
    rd(4'd12, r); chk("R1 ctl", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][29:28];
      pin_in = VEC[i][15:8];
      case (k)
        2'd0: wr(VEC[i][27:24], VEC[i][23:16]);
        2'd1: begin rd(VEC[i][27:24], r); chk($sformatf("R2/R3/R4 table %0d", i), r, VEC[i][7:0]); end
        2'd2: begin @(negedge clk); chk($sformatf("R2 table %0d", i), pin_oe, VEC[i][7:0]); end
        default: begin @(negedge clk); chk($sformatf("R3 table %0d", i), pin_out, VEC[i][7:0]); end
      endcase
    end

    // R5 / R6: latch enabled, falling edge active (ctl = 0x10)
    strb_to(1'b1);
    wr(4'd13, 8'h03);
    pin_in = 8'h5A;
    strb_to(1'b0);
    chk("R6 falling sets flag", {7'b0, irq_strb}, 8'h01);
    pin_in = 8'h11;
    strb_to(1'b1);
    pin_in = 8'h77;
    strb_to(1'b0);
    rd(4'd15, r); chk("R5 held capture", r, 8'h5A);
    rd(4'd15, r); chk("R5 live after read", r, 8'h77);
    chk("R8 offset 15 keeps flag", {7'b0, irq_strb}, 8'h01);
    rd(4'd1, r);
    chk("R8 offset 1 clears strobe flag", {7'b0, irq_strb}, 8'h00);

    // R6 rising select
    wr(4'd12, 8'h01);
    strb_to(1'b1);
    chk("R6 rising sets flag", {7'b0, irq_strb}, 8'h01);
    wr(4'd13, 8'h01);
    strb_to(1'b0);
    chk("R6 falling ignored in rising mode", {7'b0, irq_strb}, 8'h00);

    // R7: falling-edge input mode 000
    wr(4'd12, 8'h00);
    c2_to(1'b1);
    wr(4'd13, 8'h03);
    c2_to(1'b0);
    chk("R7 ctl2 falling flag, oe low", {6'b0, ctl2_oe, irq_ctl2}, 8'h01);
    rd(4'd1, r);
    chk("R8 offset 1 clears ctl2 flag", {7'b0, irq_ctl2}, 8'h00);

    // R7/R8 independent rising mode 011
    wr(4'd12, 8'h06);
    c2_to(1'b1);
    chk("R7 ctl2 rising flag", {7'b0, irq_ctl2}, 8'h01);
    wr(4'd1, 8'h00);
    chk("R8 independent keeps ctl2 flag", {7'b0, irq_ctl2}, 8'h01);
    rd(4'd13, r); chk("R12 flag read", r, 8'h02);
    wr(4'd13, 8'h02);
    chk("R12 write-1 clears", {7'b0, irq_ctl2}, 8'h00);

    // R9 handshake, falling strobe active; strb currently 0
    strb_to(1'b1);
    wr(4'd12, 8'h08);
    chk("R9 idle high", {6'b0, ctl2_oe, ctl2_out}, 8'h03);
    wr(4'd1, 8'h00);
    chk("R9 low after access", {7'b0, ctl2_out}, 8'h00);
    @(negedge clk); strb_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 still low before edge seen", {7'b0, ctl2_out}, 8'h00);
    @(negedge clk);
    chk("R9 released by strobe edge", {7'b0, ctl2_out}, 8'h01);

    // R10 pulse mode
    wr(4'd12, 8'h0A);
    rd(4'd1, r);
    chk("R10 pulse low", {7'b0, ctl2_out}, 8'h00);
    @(negedge clk);
    chk("R10 pulse one cycle", {7'b0, ctl2_out}, 8'h01);
    rd(4'd15, r);
    chk("R10 offset 15 no pulse", {7'b0, ctl2_out}, 8'h01);

    // R11 constant modes
    wr(4'd12, 8'h0C);
    chk("R11 const low", {6'b0, ctl2_oe, ctl2_out}, 8'h02);
    wr(4'd12, 8'h0E);
    chk("R11 const high", {6'b0, ctl2_oe, ctl2_out}, 8'h03);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule